// File: doc/BRIEF.md
# Nine-bit UART address-filtering receiver

This block receives asynchronous serial frames that carry a ninth bit after the usual eight data bits. A frame begins with a low start bit, continues with eight data bits (least significant first), then the ninth bit, and ends with a high stop bit. Every bit lasts a fixed number of ticks of an oversampling enable supplied from outside, and the receiver samples each bit at its centre.

The ninth bit tags each byte as either an address (1) or data (0). When address filtering is switched on, a slave node only flags bytes that are addresses aimed at it. A byte counts as aimed at it if it matches either of two addresses. The first is the node's own address, compared only on the bits that a mask enables. The second is a broadcast pattern equal to the OR of the address and the mask. When filtering is switched off, every well-formed frame is flagged, so the data that follows a matched address can be taken in.

A flagged byte and its ninth bit are held until software acknowledges them with the clear input.

Top module: `nine_bit_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits least significant first, a ninth bit and a high stop bit, each lasting OVERSAMPLE ticks. On an accepted frame, rx_byte holds the eight data bits (first received bit in bit 0) and rx_ninth holds the ninth bit.
- R2: With filt_en low, every frame with a high stop bit sets rx_done, whatever its ninth bit is.
- R3: With filt_en high, a frame whose ninth bit is 0 leaves rx_done low.
- R4: With filt_en high and ninth bit 1, a byte b is accepted when ((b XOR slave_addr) AND addr_mask) is zero. A mask bit of 0 makes that bit a don't-care.
- R5: With filt_en high and ninth bit 1, a byte b is also accepted when every bit set in (slave_addr OR addr_mask) is also set in b. The value 0xFF is therefore always accepted.
- R6: With filt_en high, an address byte that meets neither R4 nor R5 leaves rx_done low.
- R7: A low pulse on rxd that is high again at the middle of the start bit is discarded and yields no frame.
- R8: A frame whose stop bit is sampled low sets no flag. The receiver then waits for the line to go high and receives the next frame normally.
- R9: While rx_done is set and clr is low, rx_done stays set. rx_byte and rx_ninth stay unchanged, including when further frames arrive.
- R10: A one-cycle pulse on clr drops rx_done on the next clock edge when no frame completes in that cycle.
- R11: After reset, rx_done, rx_byte and rx_ninth are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | Oversampling enable, OVERSAMPLE pulses per bit |
| slave_addr | input | 8 | Node address |
| addr_mask | input | 8 | Bit enable for the address compare |
| filt_en | input | 1 | Address filtering on |
| clr | input | 1 | Acknowledge, clears rx_done |
| rx_byte | output | 8 | Held received byte |
| rx_ninth | output | 1 | Held ninth bit |
| rx_done | output | 1 | Sticky receive flag |

## Verification
The hardest cases to reach are address bytes that hit only the broadcast pattern and not the masked compare, or only the masked compare. Uniform random bytes rarely land on these, because a broadcast hit needs every set bit of the OR pattern present. The random stimulus therefore builds part of its bytes from the configured address with random don't-care bits filled in, or from the OR pattern with extra ones added, or as 0xFF. Directed frames use the known address and mask pairs to hit each case on its own. A noise pulse and a low stop bit followed by a good frame reach the recovery paths.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP,
        ST_BREAK
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ninth;
        logic              stop_ok;
    } rx_frame_t;

    // Compare only the bits enabled by the mask.
    function automatic logic mask_hit(input logic [DATA_W-1:0] b,
                                      input logic [DATA_W-1:0] addr,
                                      input logic [DATA_W-1:0] mask);
        return ((b ^ addr) & mask) == '0;
    endfunction

    // The pattern addr|mask: its ones must be present, its zeros are free.
    function automatic logic bcast_hit(input logic [DATA_W-1:0] b,
                                       input logic [DATA_W-1:0] addr,
                                       input logic [DATA_W-1:0] mask);
        logic [DATA_W-1:0] pat;
        pat = addr | mask;
        return (b & pat) == pat;
    endfunction

endpackage

// File: rtl/nbr_rx_sampler.sv
module nbr_rx_sampler
    import nbr_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rxd,
    input  logic      tick,
    output logic      frm_vld,
    output rx_frame_t frm
);

    localparam int CW    = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam int HALF  = OVERSAMPLE / 2;
    localparam int BIT_N = DATA_W + 1;
    localparam int IW    = $clog2(BIT_N + 1);

    logic [1:0]       sync_q;
    logic             line;
    rx_state_e        state;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [BIT_N-1:0] shreg;

    assign line = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            frm_vld <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= line ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_BITS: begin
                        if (cnt == CW'(OVERSAMPLE - 1)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[BIT_N-1:1]};
                            if (idx == IW'(BIT_N - 1)) state <= ST_STOP;
                            else                       idx <= idx + IW'(1);
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (cnt == CW'(OVERSAMPLE - 1)) begin
                            cnt         <= '0;
                            frm_vld     <= 1'b1;
                            frm.data    <= shreg[DATA_W-1:0];
                            frm.ninth   <= shreg[BIT_N-1];
                            frm.stop_ok <= line;
                            state       <= line ? ST_IDLE : ST_BREAK;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_BREAK: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7
    start_exit_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_START |=> state inside {ST_START, ST_IDLE, ST_BITS});

    // R1
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frm_vld |=> !frm_vld);

    // R8
    break_wait_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_BREAK && !line |=> state == ST_BREAK);

endmodule

// File: rtl/nbr_addr_filter.sv
module nbr_addr_filter
    import nbr_pkg::*;
(
    input  logic              frm_vld,
    input  rx_frame_t         frm,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              filt_en,
    output logic              accept
);

    logic addr_ok;

    always_comb begin
        addr_ok = frm.ninth && (mask_hit(frm.data, slave_addr, addr_mask) ||
                                bcast_hit(frm.data, slave_addr, addr_mask));
        accept  = frm_vld && frm.stop_ok && (!filt_en || addr_ok);
    end

    // R8
    always_comb begin
        if (frm_vld && !frm.stop_ok) stop_err_chk: assert (!accept);
    end

endmodule

// File: rtl/nbr_rx_hold.sv
module nbr_rx_hold
    import nbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  rx_frame_t         frm,
    input  logic              clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_ninth,
    output logic              rx_done
);

    logic load;

    assign load = accept && (!rx_done || clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_done  <= 1'b0;
            rx_byte  <= '0;
            rx_ninth <= 1'b0;
        end else begin
            if (load) begin
                rx_done  <= 1'b1;
                rx_byte  <= frm.data;
                rx_ninth <= frm.ninth;
            end else if (clr) begin
                rx_done  <= 1'b0;
            end
        end
    end

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done && !clr |=> rx_done);

    // R9
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done && !clr |=> $stable(rx_byte) && $stable(rx_ninth));

    // R10
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clr && !accept |=> !rx_done);

endmodule

// File: rtl/nine_bit_rx.sv
module nine_bit_rx
    import nbr_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       tick,
    input  logic [7:0] slave_addr,
    input  logic [7:0] addr_mask,
    input  logic       filt_en,
    input  logic       clr,
    output logic [7:0] rx_byte,
    output logic       rx_ninth,
    output logic       rx_done
);

    logic      frm_vld;
    rx_frame_t frm;
    logic      accept;

    nbr_rx_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .rxd     (rxd),
        .tick    (tick),
        .frm_vld (frm_vld),
        .frm     (frm)
    );

    nbr_addr_filter u_filter (
        .frm_vld    (frm_vld),
        .frm        (frm),
        .slave_addr (slave_addr),
        .addr_mask  (addr_mask),
        .filt_en    (filt_en),
        .accept     (accept)
    );

    nbr_rx_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .frm      (frm),
        .clr      (clr),
        .rx_byte  (rx_byte),
        .rx_ninth (rx_ninth),
        .rx_done  (rx_done)
    );

    // R3
    filt_ninth_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) && $past(filt_en) |-> rx_ninth);

    // R6
    filt_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) && $past(filt_en) |->
            (mask_hit(rx_byte, $past(slave_addr), $past(addr_mask)) ||
             bcast_hit(rx_byte, $past(slave_addr), $past(addr_mask))));

endmodule

// File: tb/test_nine_bit_rx.sv
`timescale 1ns/1ps
module test_nine_bit_rx;

    localparam int OVS  = 16;
    localparam int TDIV = 2;
    localparam int BITC = OVS * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] slave_addr = '0;
    logic [7:0] addr_mask = '0;
    logic       filt_en = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_ninth;
    logic       rx_done;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt = (tcnt + 1) % TDIV;
        tick = (tcnt == 0);
    end

    nine_bit_rx #(.OVERSAMPLE(OVS)) i_nine_bit_rx (
        .clk(clk), .rst(rst), .rxd(rxd), .tick(tick),
        .slave_addr(slave_addr), .addr_mask(addr_mask), .filt_en(filt_en),
        .clr(clr), .rx_byte(rx_byte), .rx_ninth(rx_ninth), .rx_done(rx_done)
    );

    function automatic logic exp_accept(input logic [7:0] b, input logic n,
                                        input logic [7:0] a, input logic [7:0] m,
                                        input logic f);
        logic mh = 1'b1;
        logic bh = 1'b1;
        if (!f) return 1'b1;
        if (!n) return 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (m[i] && (b[i] != a[i])) mh = 1'b0;
            if ((a[i] | m[i]) && !b[i]) bh = 1'b0;
        end
        return mh || bh;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rxd = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic n, input logic stop);
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) bit_time(b[i]);
        bit_time(n);
        bit_time(stop);
        bit_time(1'b1);
        bit_time(1'b1);
    endtask

    task automatic do_clear;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic frame_check(input string req, input logic [7:0] b, input logic n);
        logic e;
        do_clear();
        e = exp_accept(b, n, slave_addr, addr_mask, filt_en);
        send(b, n, 1'b1);
        check(req, rx_done, e);
        if (e) begin
            check({req, " byte"}, rx_byte, b);
            check({req, " ninth"}, rx_ninth, n);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic       n;
        int         sel;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check("R11 done", rx_done, 0);
        check("R11 byte", rx_byte, 0);
        check("R11 ninth", rx_ninth, 0);

        // R1 R2: filter off, both ninth values
        filt_en = 1'b0; slave_addr = 8'h35; addr_mask = 8'h0F;
        frame_check("R1", 8'hA6, 1'b0);
        frame_check("R2", 8'h3C, 1'b1);
        frame_check("R2", 8'h00, 1'b0);

        // R4 R5 R6 R3 with the first worked pair
        filt_en = 1'b1;
        frame_check("R4", 8'hF5, 1'b1);
        frame_check("R4", 8'h15, 1'b1);
        frame_check("R5", 8'h3F, 1'b1);
        frame_check("R6", 8'h36, 1'b1);
        frame_check("R3", 8'h35, 1'b0);
        frame_check("R5", 8'hFF, 1'b1);
        // second worked pair
        addr_mask = 8'hC0;
        frame_check("R4", 8'h3A, 1'b1);
        frame_check("R5", 8'hF5, 1'b1);
        frame_check("R6", 8'hB5, 1'b1);
        frame_check("R5", 8'hFF, 1'b1);

        // R7 start glitch
        filt_en = 1'b0;
        do_clear();
        rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * BITC) @(negedge clk);
        check("R7 glitch", rx_done, 0);
        send(8'h5A, 1'b0, 1'b1);
        check("R7 after", rx_byte, 8'h5A);

        // R8 framing error then recovery
        do_clear();
        send(8'hC3, 1'b1, 1'b0);
        check("R8 err", rx_done, 0);
        send(8'h81, 1'b1, 1'b1);
        check("R8 next", rx_done, 1);
        check("R8 byte", rx_byte, 8'h81);

        // R9 sticky hold against a new frame
        send(8'h7E, 1'b0, 1'b1);
        check("R9 done", rx_done, 1);
        check("R9 byte", rx_byte, 8'h81);
        check("R9 ninth", rx_ninth, 1);

        // R10 clear
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R10 clr", rx_done, 0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            slave_addr = 8'($urandom);
            addr_mask  = 8'($urandom);
            filt_en    = ($urandom % 4) != 0;
            n          = ($urandom % 4) != 0;
            sel        = $urandom % 4;
            case (sel)
                0: b = (slave_addr & addr_mask) | (8'($urandom) & ~addr_mask);
                1: b = (slave_addr | addr_mask) | 8'($urandom);
                2: b = 8'hFF;
                default: b = 8'($urandom);
            endcase
            frame_check("R6 rnd", b, n);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule